// File: doc/BRIEF.md
# Cell Balancing and Overcharge Controller

This block is the digital control core of a single-cell voltage supervisor. Four comparator flags come in as synchronous digital inputs. Two say whether the cell has reached the balancing detect level or has fallen to the balancing release level. The other two say the same for the overcharge detect and release levels. The block runs two hysteresis state machines, one for balancing and one for overcharge. Each machine changes status only after its qualifying condition has held without a break for a configurable number of timing ticks.

The timing tick is a half-millisecond strobe. The detect delays are long, in the tens to hundreds of milliseconds, and the release delays are short, at most a few milliseconds. A test input shortens only the detect delays, by a factor of 64.

While the cell is in overcharge, the balancing switch is turned on whatever state the balancing machine holds. A power-save input forces both outputs back to their normal-status values and clears all state. The overcharge output is described by a drive enable and a data value, so it can act as a push-pull or an open-drain pin of either polarity.

Top module: `cell_supervisor`

## Requirements
- R1: With the balancing machine in normal status, tick high and balAbove held high, the machine enters balancing status on the Nth such tick, where N is the balancing detect length. Entering balancing status drives balSwN to 0.
- R2: In balancing status, with balBelow held high for the release length in ticks, the machine returns to normal status and balSwN returns to 1. While neither balAbove nor balBelow qualifies a change, the status is kept.
- R3: If the qualifying flag drops for even one clock before its length is reached, the tick count restarts from zero.
- R4: The overcharge machine follows the same rule as R1 and R2, using ocAbove, ocBelow, ocDetSel and ocRelSel. In overcharge status the overcharge output is at its active level.
- R5: Delay selection. Detect length in ticks: code 2'b01 gives DET_UNIT (128), code 2'b00 or 2'b11 gives 2*DET_UNIT (256), code 2'b10 gives 4*DET_UNIT (512). Release length in ticks: code 2'b01 gives 1, code 2'b00 or 2'b11 gives 2, code 2'b10 gives 4.
- R6: With testMode high, each detect length is divided by 64 (256 ticks becomes 4), and the release lengths are unchanged.
- R7: While the overcharge machine is in overcharge status and powerSave is low, balSwN is 0 even when the balancing machine is in normal status.
- R8: The overcharge pin level is the overcharge status XOR ocActiveLow. In push-pull mode (ocOpenDrain=0), ocOe=1 and ocData=level. In open-drain mode (ocOpenDrain=1), ocData=0 and ocOe is the inverse of the level.
- R9: While powerSave is high, balSwN=1 and the overcharge output shows its inactive level in the same cycle. On the next edge both machines are in normal status, and all tick counts are cleared.
- R10: cfgError is 1 exactly when the selected overcharge detect length is shorter than the selected balancing detect length.
- R11: Tick counts advance only on clocks where tick is high. Without tick, neither status changes.
- R12: After a synchronous reset (rstN low at a clock edge), both machines are in normal status and the tick counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Half-millisecond timing strobe, one clock wide |
| testMode | input | 1 | Shortens the detect delays by 64 |
| powerSave | input | 1 | Forces the outputs to normal status and clears the state |
| balAbove | input | 1 | Cell is at or above the balancing detect level |
| balBelow | input | 1 | Cell is at or below the balancing release level |
| ocAbove | input | 1 | Cell is at or above the overcharge detect level |
| ocBelow | input | 1 | Cell is at or below the overcharge release level |
| balDetSel | input | 2 | Balancing detect length code |
| balRelSel | input | 2 | Balancing release length code |
| ocDetSel | input | 2 | Overcharge detect length code |
| ocRelSel | input | 2 | Overcharge release length code |
| ocOpenDrain | input | 1 | 1 selects open-drain drive for the overcharge pin |
| ocActiveLow | input | 1 | 1 makes the overcharge pin active low |
| balSwN | output | 1 | Balancing switch enable, 0 = switch on |
| ocOe | output | 1 | Overcharge pin drive enable |
| ocData | output | 1 | Overcharge pin data value |
| cfgError | output | 1 | Overcharge detect length is shorter than the balancing detect length |

## Verification
The assertions assume that the comparator flags, the tick and the mode inputs are synchronous to clk and change only between edges. The bench drives every input on the falling edge to keep to this. The entry and exit checks assume that a status can change only through a qualifying flag seen together with a tick. The stimulus keeps the configuration codes steady while a count is in progress, except where a test changes them on purpose after the count is over. The stimulus may raise both balAbove and ocAbove, or ocAbove alone, to exercise the override. It never raises an above flag and the matching below flag together.

// File: rtl/cell_sup_pkg.sv
`timescale 1ns/1ps
package cell_sup_pkg;

  localparam int NUM_CH = 2;
  localparam int CH_BAL = 0;
  localparam int CH_OC  = 1;

  // Strobes from control to the delay datapath, one bit per channel.
  typedef struct packed {
    logic [NUM_CH-1:0] cntEn;
    logic [NUM_CH-1:0] cntClr;
    logic [NUM_CH-1:0] relPhase;
  } timerCtl_t;

  // Delay code to left-shift of the base length.
  function automatic logic [1:0] selToShift(input logic [1:0] sel);
    case (sel)
      2'b01:   selToShift = 2'd0;
      2'b10:   selToShift = 2'd2;
      default: selToShift = 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/cell_sup_timers.sv
`timescale 1ns/1ps
module cell_sup_timers
  import cell_sup_pkg::*;
#(
  parameter int DET_UNIT   = 128,
  parameter int REL_UNIT   = 1,
  parameter int TEST_SHIFT = 6,
  parameter int CNT_W      = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  timerCtl_t         ctl,
  input  logic              testMode,
  input  logic [1:0]        balDetSel,
  input  logic [1:0]        balRelSel,
  input  logic [1:0]        ocDetSel,
  input  logic [1:0]        ocRelSel,
  output logic [NUM_CH-1:0] expired
);

  logic [1:0] detSelArr [NUM_CH];
  logic [1:0] relSelArr [NUM_CH];

  assign detSelArr[CH_BAL] = balDetSel;
  assign detSelArr[CH_OC]  = ocDetSel;
  assign relSelArr[CH_BAL] = balRelSel;
  assign relSelArr[CH_OC]  = ocRelSel;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] detFull;
    logic [CNT_W-1:0] detLen;
    logic [CNT_W-1:0] relLen;
    logic [CNT_W-1:0] lim;

    always_comb begin
      detFull = CNT_W'(DET_UNIT) << selToShift(detSelArr[ch]);
      detLen  = testMode ? (detFull >> TEST_SHIFT) : detFull;
      if (detLen == '0) detLen = CNT_W'(1);
      relLen  = CNT_W'(REL_UNIT) << selToShift(relSelArr[ch]);
      lim     = ctl.relPhase[ch] ? relLen : detLen;
    end

    assign expired[ch] = ctl.cntEn[ch] && (cnt >= lim - CNT_W'(1));

    always_ff @(posedge clk) begin
      if (!rstN || ctl.cntClr[ch]) begin
        cnt <= '0;
      end else if (ctl.cntEn[ch]) begin
        cnt <= expired[ch] ? '0 : cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/cell_sup_ctrl.sv
`timescale 1ns/1ps
module cell_sup_ctrl
  import cell_sup_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              powerSave,
  input  logic              balAbove,
  input  logic              balBelow,
  input  logic              ocAbove,
  input  logic              ocBelow,
  input  logic [NUM_CH-1:0] expired,
  output timerCtl_t         ctl,
  output logic              balState,
  output logic              ocState
);

  logic [NUM_CH-1:0] qualify;

  // In normal status look for the detect flag, otherwise the release flag.
  assign qualify[CH_BAL] = balState ? balBelow : balAbove;
  assign qualify[CH_OC]  = ocState  ? ocBelow  : ocAbove;

  always_comb begin
    ctl.cntEn    = qualify & {NUM_CH{tick & ~powerSave}};
    ctl.cntClr   = ~qualify | {NUM_CH{powerSave}};
    ctl.relPhase = '0;
    ctl.relPhase[CH_BAL] = balState;
    ctl.relPhase[CH_OC]  = ocState;
  end

  always_ff @(posedge clk) begin
    if (!rstN || powerSave) begin
      balState <= 1'b0;
      ocState  <= 1'b0;
    end else begin
      if (expired[CH_BAL]) balState <= ~balState;
      if (expired[CH_OC])  ocState  <= ~ocState;
    end
  end

endmodule

// File: rtl/cell_supervisor.sv
`timescale 1ns/1ps
module cell_supervisor
  import cell_sup_pkg::*;
#(
  parameter int DET_UNIT   = 128,
  parameter int REL_UNIT   = 1,
  parameter int TEST_SHIFT = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       testMode,
  input  logic       powerSave,
  input  logic       balAbove,
  input  logic       balBelow,
  input  logic       ocAbove,
  input  logic       ocBelow,
  input  logic [1:0] balDetSel,
  input  logic [1:0] balRelSel,
  input  logic [1:0] ocDetSel,
  input  logic [1:0] ocRelSel,
  input  logic       ocOpenDrain,
  input  logic       ocActiveLow,
  output logic       balSwN,
  output logic       ocOe,
  output logic       ocData,
  output logic       cfgError
);

  localparam int MAX_LEN = ((DET_UNIT > REL_UNIT) ? DET_UNIT : REL_UNIT) * 4;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  timerCtl_t         ctl;
  logic [NUM_CH-1:0] expired;
  logic              balState;
  logic              ocState;
  logic              ocLevel;

  cell_sup_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .powerSave (powerSave),
    .balAbove  (balAbove),
    .balBelow  (balBelow),
    .ocAbove   (ocAbove),
    .ocBelow   (ocBelow),
    .expired   (expired),
    .ctl       (ctl),
    .balState  (balState),
    .ocState   (ocState)
  );

  cell_sup_timers #(
    .DET_UNIT   (DET_UNIT),
    .REL_UNIT   (REL_UNIT),
    .TEST_SHIFT (TEST_SHIFT),
    .CNT_W      (CNT_W)
  ) u_timers (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .testMode  (testMode),
    .balDetSel (balDetSel),
    .balRelSel (balRelSel),
    .ocDetSel  (ocDetSel),
    .ocRelSel  (ocRelSel),
    .expired   (expired)
  );

  // Overcharge also pulls the balancing switch on; power-save forces it off.
  assign balSwN = powerSave | ~(balState | ocState);

  assign ocLevel = (ocState & ~powerSave) ^ ocActiveLow;
  assign ocOe    = ocOpenDrain ? ~ocLevel : 1'b1;
  assign ocData  = ocOpenDrain ? 1'b0 : ocLevel;

  assign cfgError = selToShift(ocDetSel) < selToShift(balDetSel);

endmodule

// File: rtl/cell_sup_checker.sv
`timescale 1ns/1ps
module cell_sup_checker (
  input logic clk,
  input logic rstN,
  input logic tick,
  input logic powerSave,
  input logic balAbove,
  input logic balBelow,
  input logic ocAbove,
  input logic ocBelow,
  input logic ocOpenDrain,
  input logic ocActiveLow,
  input logic balSwN,
  input logic ocOe,
  input logic ocData,
  input logic balState,
  input logic ocState
);

  a_r1_bal_entry: assert property (@(posedge clk) disable iff (!rstN)
    $rose(balState) |-> $past(balAbove) && $past(tick));

  a_r2_bal_exit: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(balState) && $past(rstN) && !$past(powerSave)) |-> $past(balBelow) && $past(tick));

  a_r4_oc_entry: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ocState) |-> $past(ocAbove) && $past(tick));

  a_r4_oc_exit: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ocState) && $past(rstN) && !$past(powerSave)) |-> $past(ocBelow) && $past(tick));

  a_r7_oc_forces_bal: assert property (@(posedge clk) disable iff (!rstN)
    (ocState && !powerSave) |-> !balSwN);

  a_r9_psave_outputs: assert property (@(posedge clk) disable iff (!rstN)
    powerSave |-> balSwN && (ocOpenDrain ? (ocOe == !ocActiveLow && !ocData)
                                         : (ocOe && ocData == ocActiveLow)));

  a_r9_psave_clears: assert property (@(posedge clk) disable iff (!rstN)
    powerSave |=> !balState && !ocState);

  a_r11_tick_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !powerSave) |=> $stable(balState) && $stable(ocState));

endmodule

bind cell_supervisor cell_sup_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .tick        (tick),
  .powerSave   (powerSave),
  .balAbove    (balAbove),
  .balBelow    (balBelow),
  .ocAbove     (ocAbove),
  .ocBelow     (ocBelow),
  .ocOpenDrain (ocOpenDrain),
  .ocActiveLow (ocActiveLow),
  .balSwN      (balSwN),
  .ocOe        (ocOe),
  .ocData      (ocData),
  .balState    (balState),
  .ocState     (ocState)
);

// File: tb/sim_cell_supervisor.sv
`timescale 1ns/1ps
module sim_cell_supervisor;

  logic clk = 1'b0;
  logic rstN, tick, testMode, powerSave;
  logic balAbove, balBelow, ocAbove, ocBelow;
  logic [1:0] balDetSel, balRelSel, ocDetSel, ocRelSel;
  logic ocOpenDrain, ocActiveLow;
  logic balSwN, ocOe, ocData, cfgError;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cell_supervisor u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .testMode(testMode), .powerSave(powerSave),
    .balAbove(balAbove), .balBelow(balBelow), .ocAbove(ocAbove), .ocBelow(ocBelow),
    .balDetSel(balDetSel), .balRelSel(balRelSel), .ocDetSel(ocDetSel), .ocRelSel(ocRelSel),
    .ocOpenDrain(ocOpenDrain), .ocActiveLow(ocActiveLow),
    .balSwN(balSwN), .ocOe(ocOe), .ocData(ocData), .cfgError(cfgError)
  );

  // {balAbove,balBelow,ocAbove,ocBelow}, clocks to hold, expected balSwN, expected ocData
  // Default config: detect 256 ticks, release 2 ticks, push-pull active high.
  localparam logic [21:0] VEC [0:10] = '{
    {4'b0000, 16'd10,  1'b1, 1'b0},   // R12 idle
    {4'b1000, 16'd255, 1'b1, 1'b0},   // R1 one short
    {4'b1000, 16'd1,   1'b0, 1'b0},   // R1 enter
    {4'b0000, 16'd50,  1'b0, 1'b0},   // R2 hysteresis hold
    {4'b1010, 16'd255, 1'b0, 1'b0},   // R4 one short
    {4'b1010, 16'd1,   1'b0, 1'b1},   // R4 enter
    {4'b1000, 16'd20,  1'b0, 1'b1},   // R4 hold
    {4'b1001, 16'd1,   1'b0, 1'b1},   // R4 release one short
    {4'b1001, 16'd1,   1'b0, 1'b0},   // R4 release
    {4'b0101, 16'd1,   1'b0, 1'b0},   // R2 one short
    {4'b0101, 16'd1,   1'b1, 1'b0}    // R2 release
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setFlags(input logic [3:0] f);
    {balAbove, balBelow, ocAbove, ocBelow} = f;
  endtask

  task automatic doReset();
    rstN = 1'b0; tick = 1'b1; testMode = 1'b0; powerSave = 1'b0;
    setFlags(4'b0000);
    balDetSel = 2'b00; balRelSel = 2'b00; ocDetSel = 2'b00; ocRelSel = 2'b00;
    ocOpenDrain = 1'b0; ocActiveLow = 1'b0;
    run(3);
    rstN = 1'b1;
  endtask

  function automatic logic [1:0] ocExp(input logic active, input logic od, input logic al);
    logic lvl;
    lvl = active ^ al;
    return od ? {~lvl, 1'b0} : {1'b1, lvl};
  endfunction

  initial begin
    @(negedge clk);
    doReset();

    // R12 reset state
    chk("R12 balSwN after reset", 8'(balSwN), 8'd1);
    chk("R12 ocData after reset", 8'(ocData), 8'd0);
    chk("R10 cfgError equal codes", 8'(cfgError), 8'd0);

    // table walk
    for (int i = 0; i < 11; i++) begin
      setFlags(VEC[i][21:18]);
      run(int'(VEC[i][17:2]));
      chk($sformatf("R1/R2/R4 vector %0d balSwN", i), 8'(balSwN), 8'(VEC[i][1]));
      chk($sformatf("R1/R2/R4 vector %0d ocData", i), 8'(ocData), 8'(VEC[i][0]));
    end

    // R3 interruption restarts the count
    doReset();
    setFlags(4'b1000); run(200);
    setFlags(4'b0000); run(1);
    setFlags(4'b1000); run(255);
    chk("R3 no entry after restart", 8'(balSwN), 8'd1);
    run(1);
    chk("R3 entry after full run", 8'(balSwN), 8'd0);

    // R11 no count without tick
    doReset();
    tick = 1'b0; setFlags(4'b1000); run(600);
    chk("R11 held without tick", 8'(balSwN), 8'd1);
    tick = 1'b1; run(255);
    chk("R11 one tick short", 8'(balSwN), 8'd1);
    run(1);
    chk("R11 entry after ticks", 8'(balSwN), 8'd0);

    // R6 test mode shortens detect only
    doReset();
    testMode = 1'b1; setFlags(4'b1000); run(3);
    chk("R6 test detect one short", 8'(balSwN), 8'd1);
    run(1);
    chk("R6 test detect 4 ticks", 8'(balSwN), 8'd0);
    setFlags(4'b0100); run(1);
    chk("R6 release unchanged short", 8'(balSwN), 8'd0);
    run(1);
    chk("R6 release 2 ticks", 8'(balSwN), 8'd1);

    // R5 selection codes
    doReset();
    balDetSel = 2'b01; balRelSel = 2'b10;
    setFlags(4'b1000); run(127);
    chk("R5 detect code 01 short", 8'(balSwN), 8'd1);
    run(1);
    chk("R5 detect code 01 = 128", 8'(balSwN), 8'd0);
    setFlags(4'b0100); run(3);
    chk("R5 release code 10 short", 8'(balSwN), 8'd0);
    run(1);
    chk("R5 release code 10 = 4", 8'(balSwN), 8'd1);
    doReset();
    testMode = 1'b1; ocDetSel = 2'b10; ocRelSel = 2'b01;
    setFlags(4'b0010); run(7);
    chk("R5 oc detect code 10 short", 8'(ocData), 8'd0);
    run(1);
    chk("R5 oc detect code 10 = 512", 8'(ocData), 8'd1);
    setFlags(4'b0001); run(1);
    chk("R5 oc release code 01 = 1", 8'(ocData), 8'd0);
    doReset();
    balDetSel = 2'b11; setFlags(4'b1000); run(255);
    chk("R5 detect code 11 short", 8'(balSwN), 8'd1);
    run(1);
    chk("R5 detect code 11 = 256", 8'(balSwN), 8'd0);

    // R7 override and R8 output forms
    doReset();
    testMode = 1'b1; setFlags(4'b0010); run(4);
    chk("R7 oc drives switch on", 8'(balSwN), 8'd0);
    for (int m = 0; m < 4; m++) begin
      ocOpenDrain = m[1]; ocActiveLow = m[0]; #1;
      chk($sformatf("R8 active form %0d", m), 8'({ocOe, ocData}), 8'(ocExp(1'b1, m[1], m[0])));
    end
    ocOpenDrain = 1'b0; ocActiveLow = 1'b0;
    setFlags(4'b0001); run(2);
    chk("R7 switch off after oc release", 8'(balSwN), 8'd1);
    for (int m = 0; m < 4; m++) begin
      ocOpenDrain = m[1]; ocActiveLow = m[0]; #1;
      chk($sformatf("R8 inactive form %0d", m), 8'({ocOe, ocData}), 8'(ocExp(1'b0, m[1], m[0])));
    end

    // R9 power-save
    doReset();
    testMode = 1'b1; setFlags(4'b1010); run(4);
    chk("R9 setup in oc", 8'(ocData), 8'd1);
    powerSave = 1'b1; ocOpenDrain = 1'b1; ocActiveLow = 1'b1; #1;
    chk("R9 switch off in power-save", 8'(balSwN), 8'd1);
    chk("R9 oc inactive in power-save", 8'({ocOe, ocData}), 8'(ocExp(1'b0, 1'b1, 1'b1)));
    ocOpenDrain = 1'b0; ocActiveLow = 1'b0;
    run(1);
    powerSave = 1'b0; setFlags(4'b0000); run(3);
    chk("R9 bal cleared", 8'(balSwN), 8'd1);
    chk("R9 oc cleared", 8'(ocData), 8'd0);
    setFlags(4'b0010); run(3);
    powerSave = 1'b1; run(1);
    powerSave = 1'b0; run(3);
    chk("R9 count cleared", 8'(ocData), 8'd0);
    run(1);
    chk("R9 fresh count completes", 8'(ocData), 8'd1);

    // R10 configuration error
    balDetSel = 2'b00; ocDetSel = 2'b01; #1;
    chk("R10 oc shorter", 8'(cfgError), 8'd1);
    balDetSel = 2'b01; ocDetSel = 2'b10; #1;
    chk("R10 oc longer", 8'(cfgError), 8'd0);
    balDetSel = 2'b10; ocDetSel = 2'b11; #1;
    chk("R10 oc 256 vs bal 512", 8'(cfgError), 8'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule